// File: doc/BRIEF.md
# Hidden Serial Unlock Controller for a Memory Chip Select

The block sits between a host's chip select and an external static RAM and hides a small serial channel to a bank of eight 8-bit clock registers, all inside the RAM's own address window. It watches ordinary bus accesses (a chip select qualified by an output strobe for reads or a write strobe for writes). The data pin carries one bit per access. A fixed 64-bit key must be written one bit per write access before the channel opens. While the key is being sent, every access still reaches the RAM. Once the key has matched, the next 64 accesses are steered to the registers, one bit each, and the RAM stays deselected.

A read access during matching starts the match over. A wrong key bit freezes the matcher until the next read. In the open channel, serial writes collect in a holding byte that lands in its register only when the byte's last bit slot is written. An abort from a reset pin (when the registers allow it) or from a power-fail input closes the channel and drops any partial byte. A power failure also forces the RAM deselected and blocks all accesses.

Top module: `phantom_access_ctrl`

## Requirements
- R1: While the channel is closed and power is good, `ce_out_n` equals `ce_in_n` combinationally, including during the key write accesses.
- R2: The key is the 64-bit value 0x5CA33AC55CA33AC5. The k-th write access after a restart must carry bit k of it, so bytes go out C5, 3A, A3, 5C, C5, 3A, A3, 5C, each starting from bit 0. Sixty-four matching bits open the channel once that write access ends.
- R3: A key bit that does not match freezes the matcher. Later writes, including correct ones, are ignored until a read access restarts matching at bit 0.
- R4: A read access while the channel is closed restarts matching at key bit 0. A key that is split across such a read does not open the channel.
- R5: While the channel is open, `ce_out_n` is 1 for the 64 transfer accesses and between them, even when `ce_in_n` is low without a strobe. The channel closes after the 64th transfer access. An access is a write when `we_n` is low, and a read when `we_n` is high and `oe_n` is low.
- R6: Transfer slot i (0..63) maps to register i/8, bit i%8. A read access drives that bit on `q_out` with `q_oe` high from the clock edge after the access starts until the access ends.
- R7: `q_oe` is low, and `q_out` is 0, at all times other than an open-channel read access.
- R8: Serial write bits collect per register. A register changes only when slot bit 7 of its byte is a write. The new value then takes the written bits and keeps the old value in the slots that were read. If bit 7 is a read, the register is unchanged.
- R9: Accesses with `ce_in_n` high neither advance matching nor transfer.
- R10: When `rst_pin_n` is low and bit 4 of register 4 is 0, any transfer is aborted. The channel closes, a partial byte is dropped, and the registers keep their values. When that bit is 1, `rst_pin_n` has no effect.
- R11: While `pwr_fail` is high, `ce_out_n` is 1, every access is ignored, and any transfer is aborted without changing the registers.
- R12: After an abort, write accesses are ignored until a read access restarts matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the controller |
| ce_in_n | input | 1 | Chip select from the host, active low |
| oe_n | input | 1 | Output strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| d_in | input | 1 | Serial data bit for write accesses |
| rst_pin_n | input | 1 | Abort request, active low, gated by register 4 bit 4 |
| pwr_fail | input | 1 | Supply below threshold, active high |
| ce_out_n | output | 1 | Chip select to the RAM, active low |
| q_out | output | 1 | Serial read data |
| q_oe | output | 1 | Drive enable for `q_out` |

## Verification
A reference model in the bench runs alongside the design on every clock. It is exercised by a clean key followed by a full write of all registers and a full read back, which separates correct bit ordering from swapped bytes or bits. Keys broken by a wrong bit, or split by a read, tell a frozen matcher apart from one that skips or resumes. A transfer that mixes reads and writes inside a byte, accesses interleaved with the chip select high, and reset-pin and power-fail aborts in the middle of a byte each check that only a completed byte reaches a register. The reset-pin pulse is repeated with the guard bit set, to confirm the pin is then ignored.

// File: rtl/pa_pkg.sv
package pa_pkg;

  localparam int unsigned KEY_LEN = 64;
  localparam logic [KEY_LEN-1:0] KEY_DEFAULT = 64'h5CA3_3AC5_5CA3_3AC5;

  // register index of a serial slot
  function automatic int unsigned slot_reg(input int unsigned idx, input int unsigned width);
    return idx / width;
  endfunction

  // bit position of a serial slot within its register
  function automatic int unsigned slot_bit(input int unsigned idx, input int unsigned width);
    return idx % width;
  endfunction

  // value a register bit takes on commit: written bits win, read slots keep old data
  function automatic logic merge_bit(input logic cur, input logic held, input logic held_v);
    return held_v ? held : cur;
  endfunction

endpackage

// File: rtl/pa_cycle_detect.sv
module pa_cycle_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_in_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic abort,
  input  logic unlocked,
  output logic wr_ev,
  output logic rd_ev,
  output logic acc_now,
  output logic acc_cont,
  output logic clk_sel
);
  logic acc_prev;
  logic owner;
  logic raw_start;

  assign acc_now   = !ce_in_n && (!we_n || !oe_n);
  assign raw_start = acc_now && !acc_prev;
  assign acc_cont  = acc_now && acc_prev;
  assign wr_ev     = raw_start && !abort && !we_n;
  assign rd_ev     = raw_start && !abort && we_n;
  // an access keeps the owner it had when it began
  assign clk_sel   = acc_cont ? owner : (unlocked && !abort);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_prev <= 1'b0;
      owner    <= 1'b0;
    end else begin
      acc_prev <= acc_now;
      if (!acc_now)
        owner <= 1'b0;
      else if (raw_start)
        owner <= unlocked && !abort;
    end
  end
endmodule

// File: rtl/pa_unlock_matcher.sv
module pa_unlock_matcher #(
  parameter int unsigned KEY_LEN = pa_pkg::KEY_LEN,
  parameter logic [KEY_LEN-1:0] KEY = pa_pkg::KEY_DEFAULT,
  localparam int unsigned PTR_W = $clog2(KEY_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ev,
  input  logic             rd_ev,
  input  logic             d_in,
  input  logic             abort,
  input  logic             xfer_done,
  output logic             unlocked,
  output logic             dead,
  output logic [PTR_W-1:0] ptr,
  output logic             key_hit
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(KEY_LEN - 1);

  logic bit_ok;
  assign bit_ok  = (d_in == KEY[ptr]);
  assign key_hit = !unlocked && wr_ev && !dead && bit_ok && (ptr == PTR_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      dead     <= 1'b0;
      unlocked <= 1'b0;
    end else if (abort) begin
      ptr      <= '0;
      dead     <= 1'b1;
      unlocked <= 1'b0;
    end else if (unlocked) begin
      if (xfer_done) begin
        unlocked <= 1'b0;
        ptr      <= '0;
        dead     <= 1'b0;
      end
    end else if (rd_ev) begin
      ptr  <= '0;
      dead <= 1'b0;
    end else if (wr_ev && !dead) begin
      if (!bit_ok)
        dead <= 1'b1;
      else if (ptr == PTR_LAST) begin
        unlocked <= 1'b1;
        ptr      <= '0;
      end else
        ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/pa_xfer_engine.sv
module pa_xfer_engine #(
  parameter int unsigned REG_N     = 8,
  parameter int unsigned REG_W     = 8,
  parameter int unsigned GUARD_REG = 4,
  parameter int unsigned GUARD_BIT = 4,
  localparam int unsigned SLOTS  = REG_N * REG_W,
  localparam int unsigned IDX_W  = $clog2(SLOTS),
  localparam int unsigned RSEL_W = $clog2(REG_N),
  localparam int unsigned BSEL_W = $clog2(REG_W)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic unlocked,
  input  logic wr_ev,
  input  logic rd_ev,
  input  logic d_in,
  input  logic abort,
  input  logic acc_now,
  output logic xfer_done,
  output logic q_bit,
  output logic rd_busy,
  output logic rst_honour
);
  logic [IDX_W-1:0]  idx;
  logic [RSEL_W-1:0] rsel;
  logic [BSEL_W-1:0] bsel;
  logic [REG_W-1:0]  hold;
  logic [REG_W-1:0]  held;
  logic [REG_W-1:0]  commit_val;
  logic [REG_W-1:0]  view [REG_N];
  logic              step;
  logic              byte_end;
  logic              commit;

  assign rsel      = RSEL_W'(pa_pkg::slot_reg(32'(idx), REG_W));
  assign bsel      = BSEL_W'(pa_pkg::slot_bit(32'(idx), REG_W));
  assign step      = unlocked && (wr_ev || rd_ev);
  assign byte_end  = (bsel == BSEL_W'(REG_W - 1));
  assign xfer_done = step && (idx == IDX_W'(SLOTS - 1));
  assign commit    = unlocked && wr_ev && byte_end;

  always_comb begin
    for (int j = 0; j < REG_W; j++) begin
      if (BSEL_W'(j) == bsel)
        commit_val[j] = d_in;
      else
        commit_val[j] = pa_pkg::merge_bit(view[rsel][j], hold[j], held[j]);
    end
  end

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    logic [REG_W-1:0] val;
    always_ff @(posedge clk) begin
      if (!rst_n)
        val <= '0;
      else if (commit && (rsel == RSEL_W'(g)))
        val <= commit_val;
    end
    assign view[g] = val;
  end

  assign rst_honour = !view[GUARD_REG][GUARD_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx  <= '0;
      hold <= '0;
      held <= '0;
    end else if (abort || !unlocked) begin
      idx  <= '0;
      held <= '0;
    end else if (step) begin
      idx <= xfer_done ? '0 : idx + 1'b1;
      if (byte_end)
        held <= '0;
      else if (wr_ev) begin
        hold[bsel] <= d_in;
        held[bsel] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_bit   <= 1'b0;
      rd_busy <= 1'b0;
    end else begin
      if (unlocked && rd_ev)
        q_bit <= view[rsel][bsel];
      if (abort || !acc_now)
        rd_busy <= 1'b0;
      else if (unlocked && rd_ev)
        rd_busy <= 1'b1;
    end
  end
endmodule

// File: rtl/phantom_access_ctrl.sv
module phantom_access_ctrl #(
  parameter int unsigned KEY_LEN   = pa_pkg::KEY_LEN,
  parameter logic [KEY_LEN-1:0] KEY = pa_pkg::KEY_DEFAULT,
  parameter int unsigned REG_N     = 8,
  parameter int unsigned REG_W     = 8,
  parameter int unsigned GUARD_REG = 4,
  parameter int unsigned GUARD_BIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_in_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic d_in,
  input  logic rst_pin_n,
  input  logic pwr_fail,
  output logic ce_out_n,
  output logic q_out,
  output logic q_oe
);
  localparam int unsigned PTR_W = $clog2(KEY_LEN);

  logic wr_ev, rd_ev, acc_now, acc_cont, clk_sel;
  logic unlocked, dead, key_hit, xfer_done;
  logic q_bit, rd_busy, rst_honour, abort;
  logic [PTR_W-1:0] match_ptr;

  assign abort    = pwr_fail || (!rst_pin_n && rst_honour);
  assign ce_out_n = ce_in_n || pwr_fail || clk_sel;
  assign q_oe     = rd_busy;
  assign q_out    = rd_busy && q_bit;

  pa_cycle_detect u_detect (
    .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n), .oe_n(oe_n), .we_n(we_n),
    .abort(abort), .unlocked(unlocked), .wr_ev(wr_ev), .rd_ev(rd_ev),
    .acc_now(acc_now), .acc_cont(acc_cont), .clk_sel(clk_sel)
  );

  pa_unlock_matcher #(.KEY_LEN(KEY_LEN), .KEY(KEY)) u_match (
    .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev), .rd_ev(rd_ev), .d_in(d_in),
    .abort(abort), .xfer_done(xfer_done), .unlocked(unlocked), .dead(dead),
    .ptr(match_ptr), .key_hit(key_hit)
  );

  pa_xfer_engine #(.REG_N(REG_N), .REG_W(REG_W), .GUARD_REG(GUARD_REG), .GUARD_BIT(GUARD_BIT)) u_xfer (
    .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .wr_ev(wr_ev), .rd_ev(rd_ev),
    .d_in(d_in), .abort(abort), .acc_now(acc_now), .xfer_done(xfer_done),
    .q_bit(q_bit), .rd_busy(rd_busy), .rst_honour(rst_honour)
  );
endmodule

// File: rtl/phantom_access_chk.sv
module phantom_access_chk #(
  parameter int unsigned PTR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_in_n,
  input logic             pwr_fail,
  input logic             ce_out_n,
  input logic             q_out,
  input logic             q_oe,
  input logic             unlocked,
  input logic             dead,
  input logic [PTR_W-1:0] ptr,
  input logic             wr_ev,
  input logic             rd_ev,
  input logic             abort,
  input logic             key_hit,
  input logic             acc_now
);
  a_r1_locked_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !pwr_fail && !acc_now) |-> (ce_out_n == ce_in_n));

  a_r2_open_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_hit));

  a_r3_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (dead && !unlocked && !rd_ev) |=> dead);

  a_r4_read_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && !unlocked) |=> (ptr == '0 && !dead));

  a_r5_open_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && !acc_now && !abort) |-> ce_out_n);

  a_r6_drive_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_oe) |-> $past(rd_ev && unlocked));

  a_r7_quiet_output: assert property (@(posedge clk) disable iff (!rst_n)
    !q_oe |-> !q_out);

  a_r11_pf_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> ce_out_n);

  a_r11_pf_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> !(wr_ev || rd_ev));
endmodule

bind phantom_access_ctrl phantom_access_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_in_n(ce_in_n), .pwr_fail(pwr_fail),
  .ce_out_n(ce_out_n), .q_out(q_out), .q_oe(q_oe), .unlocked(unlocked),
  .dead(dead), .ptr(match_ptr), .wr_ev(wr_ev), .rd_ev(rd_ev), .abort(abort),
  .key_hit(key_hit), .acc_now(acc_now)
);

// File: tb/phantom_access_ctrl_test.sv
`timescale 1ns/1ps
module phantom_access_ctrl_test;
  typedef bit [7:0] regs8_t [8];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b1, oe = 1'b1, we = 1'b1, din = 1'b0, rpin = 1'b1, pf = 1'b0;
  logic ce_out_n, q_out, q_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  phantom_access_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ce_in_n(ce), .oe_n(oe), .we_n(we), .d_in(din),
    .rst_pin_n(rpin), .pwr_fail(pf), .ce_out_n(ce_out_n), .q_out(q_out), .q_oe(q_oe)
  );

  function automatic bit key_bit(int k);
    bit [7:0] tab [4] = '{8'hC5, 8'h3A, 8'hA3, 8'h5C};
    return tab[(k / 8) % 4][k % 8];
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_ptr, m_idx;
  bit m_dead, m_open, m_prev, m_own, m_rdb, m_qb;
  bit [7:0] m_regs [8];
  bit [7:0] m_hold, m_mask;

  function automatic bit m_abort_now();
    return pf || (!rpin && !m_regs[4][4]);
  endfunction

  always @(posedge clk) begin
    bit acc, ab, st, ev;
    int ri, bi;
    if (!rst_n) begin
      m_ptr = 0; m_idx = 0; m_dead = 0; m_open = 0; m_prev = 0; m_own = 0;
      m_rdb = 0; m_qb = 0; m_hold = 0; m_mask = 0;
      foreach (m_regs[i]) m_regs[i] = 0;
    end else begin
      acc = !ce && (!we || !oe);
      ab  = m_abort_now();
      st  = acc && !m_prev;
      ev  = st && !ab;
      if (!acc) m_own = 0; else if (st) m_own = m_open && !ab;
      if (ab) begin
        m_idx = 0; m_mask = 0; m_rdb = 0; m_open = 0; m_ptr = 0; m_dead = 1;
      end else begin
        if (!acc) m_rdb = 0;
        if (m_open) begin
          if (ev) begin
            ri = m_idx / 8; bi = m_idx % 8;
            if (!we) begin
              m_hold[bi] = din; m_mask[bi] = 1;
              if (bi == 7) begin
                for (int j = 0; j < 8; j++) if (m_mask[j]) m_regs[ri][j] = m_hold[j];
                m_mask = 0;
              end
            end else begin
              m_qb = m_regs[ri][bi]; m_rdb = 1;
              if (bi == 7) m_mask = 0;
            end
            if (m_idx == 63) begin
              m_idx = 0; m_open = 0; m_ptr = 0; m_dead = 0;
            end else m_idx++;
          end
        end else if (ev) begin
          if (we) begin m_ptr = 0; m_dead = 0; end
          else if (!m_dead) begin
            if (din == key_bit(m_ptr)) begin
              if (m_ptr == 63) begin m_open = 1; m_ptr = 0; end
              else m_ptr++;
            end else m_dead = 1;
          end
        end
      end
      m_prev = acc;
    end
  end

  // compare on every clock, between edges
  always @(negedge clk) begin
    bit acc, cont, sel, exp_ce;
    #1;
    if (rst_n && !done) begin
      acc    = !ce && (!we || !oe);
      cont   = acc && m_prev;
      sel    = cont ? m_own : (m_open && !m_abort_now());
      exp_ce = ce || pf || sel;
      check(ce_out_n === exp_ce, "R1,R5,R11", "model ce_out_n", ce_out_n, exp_ce);
      check(q_oe === m_rdb, "R6,R7", "model q_oe", q_oe, m_rdb);
      check(q_out === (m_rdb && m_qb), "R6,R7", "model q_out", q_out, m_rdb && m_qb);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic access(bit is_wr, bit d, output bit qv, output bit qe, output bit co);
    @(negedge clk); ce = 0; we = !is_wr; oe = is_wr; din = d;
    @(negedge clk); #1; qv = q_out; qe = q_oe; co = ce_out_n;
    @(negedge clk); ce = 1; we = 1; oe = 1;
  endtask

  task automatic wr_bit(bit d, output bit co);
    bit qv, qe;
    access(1, d, qv, qe, co);
    check(qe == 0, "R7", "q_oe in write access", qe, 0);
  endtask

  task automatic rd_bit(output bit qv, output bit qe, output bit co);
    access(0, 0, qv, qe, co);
  endtask

  task automatic send_key(int first, int last, bit lead_read);
    bit qv, qe, co;
    if (lead_read) rd_bit(qv, qe, co);
    for (int k = first; k <= last; k++) begin
      wr_bit(key_bit(k), co);
      check(co == 0, "R1", "ce_out_n in key write", co, 0);
    end
  endtask

  task automatic probe(bit exp_open, string req);
    @(negedge clk); ce = 0; #1;
    check(ce_out_n == exp_open, req, "channel state probe", ce_out_n, exp_open);
    @(negedge clk); ce = 1;
  endtask

  task automatic write_regs(regs8_t v);
    bit co;
    for (int i = 0; i < 64; i++) begin
      wr_bit(v[i / 8][i % 8], co);
      check(co == 1, "R5", "ce_out_n in write transfer", co, 1);
    end
  endtask

  task automatic read_regs(output regs8_t v, input bit ce_high_gaps);
    bit qv, qe, co;
    for (int i = 0; i < 64; i++) begin
      rd_bit(qv, qe, co);
      check(qe == 1, "R6", "q_oe in read transfer", qe, 1);
      check(co == 1, "R5", "ce_out_n in read transfer", co, 1);
      v[i / 8][i % 8] = qv;
      if (ce_high_gaps) begin
        @(negedge clk); oe = 0;
        @(negedge clk); oe = 1; we = 0;
        @(negedge clk); we = 1;
      end
    end
  endtask

  task automatic compare_regs(regs8_t got, regs8_t exp, string req);
    for (int r = 0; r < 8; r++)
      check(got[r] == exp[r], req, $sformatf("register %0d", r), got[r], exp[r]);
  endtask

  // ---------------- directed sequence ----------------
  initial begin
    regs8_t a, b, c, got, exp;
    bit qv, qe, co;
    a = '{8'h12, 8'h34, 8'h56, 8'h78, 8'h0A, 8'hBC, 8'hDE, 8'hF1};
    b = '{8'h21, 8'h43, 8'h65, 8'h87, 8'h1A, 8'hCB, 8'hED, 8'h1F};
    c = '{8'h9C, 8'h27, 8'h40, 8'hE3, 8'h05, 8'h6B, 8'hD8, 8'h3E};
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check(q_oe == 0, "R7", "reset q_oe", q_oe, 0);
    check(q_out == 0, "R7", "reset q_out", q_out, 0);
    check(ce_out_n == 1, "R1", "reset ce_out_n", ce_out_n, 1);
    probe(0, "R1");

    // R2: key then full write and read back
    send_key(0, 63, 1);
    probe(1, "R2");
    write_regs(a);
    probe(0, "R5");
    send_key(0, 63, 1);
    read_regs(got, 0);
    compare_regs(got, a, "R2,R6");

    // R3: a wrong bit freezes the matcher
    rd_bit(qv, qe, co);
    send_key(0, 4, 0);
    wr_bit(!key_bit(5), co);
    send_key(6, 63, 0);
    probe(0, "R3");
    send_key(0, 63, 1);
    probe(1, "R3");
    read_regs(got, 0);
    compare_regs(got, a, "R3");

    // R4: a read splits the key
    send_key(0, 29, 1);
    rd_bit(qv, qe, co);
    send_key(30, 63, 0);
    probe(0, "R4");
    send_key(0, 29, 1);
    send_key(0, 63, 1);
    probe(1, "R4");
    read_regs(got, 0);

    // R8: mixed reads and writes within a byte
    send_key(0, 63, 1);
    for (int i = 0; i < 7; i++) wr_bit(1'b1, co);
    rd_bit(qv, qe, co);
    for (int i = 0; i < 4; i++) rd_bit(qv, qe, co);
    for (int i = 0; i < 4; i++) wr_bit(1'b1, co);
    for (int i = 16; i < 64; i++) rd_bit(qv, qe, co);
    send_key(0, 63, 1);
    read_regs(got, 0);
    exp = a; exp[1] = (a[1] & 8'h0F) | 8'hF0;
    compare_regs(got, exp, "R8");

    // R9: accesses with chip select high are ignored
    send_key(0, 63, 1);
    for (int i = 0; i < 64; i++) begin
      wr_bit(c[i / 8][i % 8], co);
      @(negedge clk); we = 0; din = !c[i / 8][i % 8];
      @(negedge clk); we = 1;
    end
    send_key(0, 63, 1);
    read_regs(got, 1);
    compare_regs(got, c, "R9");

    // R10 and R12: reset pin honoured while register 4 bit 4 is 0
    send_key(0, 63, 1);
    for (int i = 0; i < 8; i++) wr_bit(1'b1, co);
    for (int i = 0; i < 4; i++) wr_bit(1'b0, co);
    @(negedge clk); rpin = 0;
    @(negedge clk); rpin = 1;
    probe(0, "R10");
    send_key(0, 63, 0);
    probe(0, "R12");
    send_key(0, 63, 1);
    read_regs(got, 0);
    exp = c; exp[0] = 8'hFF;
    compare_regs(got, exp, "R10");

    // R10: reset pin ignored once register 4 bit 4 is 1
    send_key(0, 63, 1);
    write_regs(b);
    send_key(0, 63, 1);
    for (int i = 0; i < 20; i++) begin
      rd_bit(qv, qe, co);
      got[i / 8][i % 8] = qv;
    end
    @(negedge clk); rpin = 0;
    @(negedge clk); rpin = 1;
    probe(1, "R10");
    for (int i = 20; i < 64; i++) begin
      rd_bit(qv, qe, co);
      got[i / 8][i % 8] = qv;
    end
    compare_regs(got, b, "R10");

    // R11: power fail during a transfer
    send_key(0, 63, 1);
    for (int i = 0; i < 6; i++) wr_bit(1'b0, co);
    @(negedge clk); pf = 1;
    probe(1, "R11");
    access(1, 1'b0, qv, qe, co);
    check(co == 1, "R11", "ce_out_n during power fail", co, 1);
    access(0, 1'b0, qv, qe, co);
    check(qe == 0, "R11", "q_oe during power fail", qe, 0);
    @(negedge clk); pf = 0;
    probe(0, "R11");
    send_key(0, 63, 0);
    probe(0, "R12");
    send_key(0, 63, 1);
    read_regs(got, 0);
    compare_regs(got, b, "R11");

    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule